// File: doc/BRIEF.md
# Byte Register Bank with Pointer-Pair Views

This block is the general-purpose register storage of a small 8-bit processor core. It holds thirty-two byte-wide registers, numbered 0 to 31. Two independent read ports each return one byte. A single write port changes one byte per clock. The six highest registers can also be handled in pairs as three 16-bit address pointers, named X, Y and Z. A pointer can be written as a whole word in one clock, which suits post-increment and pre-decrement addressing, and it can be read back as one word.

The Z pair has one more use: it is the only pair allowed to address program memory, so it is exported on a dedicated output at all times. The block also has an operand legality check. Some operations accept only the upper half of the file. For a given register index, the check reports whether such an operation may use it. A clear-type operation may use any index. Decoding and arithmetic take place outside this block.

Top module: `gpr_bank`

## Requirements
- R1: While `rst` is high at a clock edge, every register becomes 0x00. All registered outputs (`rd_a_data`, `rd_b_data`, `pr_data`, `chk_ok`) become 0 at that edge. `zptr` then reads 0x0000.
- R2: Each of the two read ports returns, one clock after its index is sampled, the byte the indexed register held just before that edge. Indices 0 to 31 are all addressable.
- R3: When `wr_en` is high at an edge, `wr_data` is stored into register `wr_idx`.
- R4: There is no write-through path. A read of a register that is being written at the same edge returns the old value, and the new value appears one cycle later.
- R5: The pointer select encoding is 0 = X (registers 26/27), 1 = Y (28/29) and 2 = Z (30/31). The even, lower-numbered register is the low byte `[7:0]` and the odd one is the high byte `[15:8]`. `pr_data` returns the pointer chosen by `pr_sel` as it was before the edge, with one cycle of latency.
- R6: When `pw_en` is high and `pw_sel` is 0 to 2, both bytes of the chosen pair take `pw_data` at the same edge. A `pw_sel` of 3 writes nothing, and a `pr_sel` of 3 reads 0x0000.
- R7: If a pointer write and a byte write target the same register at the same edge, the pointer write wins. A byte write to any other register at that edge still takes effect.
- R8: `zptr` always equals `{reg31, reg30}` and shows an update right after the edge that wrote it.
- R9: `chk_ok` is registered (one cycle of latency). It is 0 when `chk_upper_only` is 1 and `chk_idx` is below 16, and 1 otherwise. With `chk_upper_only` at 0 (a clear-type operation) it is 1 for every index 0 to 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rd_a_idx | input | 5 | Read port A register index |
| rd_a_data | output | 8 | Read port A data (registered) |
| rd_b_idx | input | 5 | Read port B register index |
| rd_b_data | output | 8 | Read port B data (registered) |
| wr_en | input | 1 | Byte write enable |
| wr_idx | input | 5 | Byte write register index |
| wr_data | input | 8 | Byte write data |
| pw_en | input | 1 | Pointer word write enable |
| pw_sel | input | 2 | Pointer write select (0 X, 1 Y, 2 Z, 3 none) |
| pw_data | input | 16 | Pointer word write data |
| pr_sel | input | 2 | Pointer read select (3 returns zero) |
| pr_data | output | 16 | Pointer word read data (registered) |
| zptr | output | 16 | Program-memory pointer, current Z pair |
| chk_idx | input | 5 | Register index under legality check |
| chk_upper_only | input | 1 | 1 when the operation accepts only registers 16 to 31 |
| chk_ok | output | 1 | Operand legal (registered) |

## Verification
The assertions take for granted that reset is applied at the start, before any of the storage is trusted. They also assume that every input is a known value at each edge, so the pair index derived from `pw_sel` and the byte index derived from `wr_idx` always name real registers. The bench holds reset from time zero and drives every input at the falling edge. Its random phase includes the unused select value 3 and deliberately steers many indices into the pointer range, so that pointer and byte writes collide on the same register.

// File: rtl/gpr_pkg.sv
package gpr_pkg;
  // pointer pair selector; value 3 selects nothing
  typedef enum logic [1:0] {
    PTR_X    = 2'd0,
    PTR_Y    = 2'd1,
    PTR_Z    = 2'd2,
    PTR_NONE = 2'd3
  } ptr_sel_e;

  localparam int PTR_PAIRS = 3;
endpackage

// File: rtl/gpr_storage.sv
module gpr_storage #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 32,
  localparam int IDX_W    = $clog2(NUM_REGS),
  localparam int PTR_BASE = NUM_REGS - 2 * gpr_pkg::PTR_PAIRS
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic                              wr_en,
  input  logic [IDX_W-1:0]                  wr_idx,
  input  logic [DATA_W-1:0]                 wr_data,
  input  logic                              pw_en,
  input  logic [1:0]                        pw_sel,
  input  logic [2*DATA_W-1:0]               pw_data,
  output logic [NUM_REGS-1:0][DATA_W-1:0]   regs_q
);
  for (genvar i = 0; i < NUM_REGS; i++) begin : g_reg
    logic byte_hit;
    assign byte_hit = wr_en && (wr_idx == IDX_W'(i));

    if (i >= PTR_BASE) begin : g_ptr
      localparam int  PAIR = (i - PTR_BASE) / 2;
      localparam bit  HI   = ((i - PTR_BASE) % 2) == 1;
      logic              word_hit;
      logic [DATA_W-1:0] word_byte;
      assign word_hit  = pw_en && (pw_sel == 2'(PAIR));
      assign word_byte = HI ? pw_data[2*DATA_W-1:DATA_W] : pw_data[DATA_W-1:0];

      always_ff @(posedge clk) begin
        if (rst)           regs_q[i] <= '0;
        else if (word_hit) regs_q[i] <= word_byte;  // word write wins
        else if (byte_hit) regs_q[i] <= wr_data;
      end
    end else begin : g_plain
      always_ff @(posedge clk) begin
        if (rst)           regs_q[i] <= '0;
        else if (byte_hit) regs_q[i] <= wr_data;
      end
    end
  end
endmodule

// File: rtl/gpr_rd_port.sv
module gpr_rd_port #(
  parameter int DATA_W   = 8,
  parameter int NUM_REGS = 32,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic                            clk,
  input  logic                            rst,
  input  logic [IDX_W-1:0]                idx,
  input  logic [NUM_REGS-1:0][DATA_W-1:0] regs,
  output logic [DATA_W-1:0]               rd_q
);
  // sampled from the stored state: no forwarding of a same-edge write
  always_ff @(posedge clk) begin
    if (rst) rd_q <= '0;
    else     rd_q <= regs[idx];
  end
endmodule

// File: rtl/gpr_ptr_view.sv
module gpr_ptr_view #(
  parameter int DATA_W = 8,
  localparam int PAIRS = gpr_pkg::PTR_PAIRS,
  localparam int WORD_W = 2 * DATA_W
) (
  input  logic                              clk,
  input  logic                              rst,
  input  logic [2*PAIRS-1:0][DATA_W-1:0]    ptr_bytes,
  input  logic [1:0]                        pr_sel,
  output logic [WORD_W-1:0]                 pr_q,
  output logic [WORD_W-1:0]                 zptr
);
  import gpr_pkg::*;

  logic [PAIRS-1:0][WORD_W-1:0] words;
  for (genvar p = 0; p < PAIRS; p++) begin : g_word
    assign words[p] = {ptr_bytes[2*p+1], ptr_bytes[2*p]};
  end

  logic [WORD_W-1:0] pick;
  always_comb begin
    unique case (ptr_sel_e'(pr_sel))
      PTR_X:   pick = words[0];
      PTR_Y:   pick = words[1];
      PTR_Z:   pick = words[2];
      default: pick = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) pr_q <= '0;
    else     pr_q <= pick;
  end

  assign zptr = words[PAIRS-1];
endmodule

// File: rtl/gpr_legal.sv
module gpr_legal #(
  parameter int NUM_REGS   = 32,
  parameter int UPPER_FROM = 16,
  localparam int IDX_W = $clog2(NUM_REGS)
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [IDX_W-1:0] chk_idx,
  input  logic             chk_upper_only,
  output logic             chk_ok_q
);
  logic low_half;
  assign low_half = chk_idx < IDX_W'(UPPER_FROM);

  always_ff @(posedge clk) begin
    if (rst) chk_ok_q <= 1'b0;
    else     chk_ok_q <= !(chk_upper_only && low_half);
  end
endmodule

// File: rtl/gpr_bank.sv
module gpr_bank #(
  parameter int DATA_W     = 8,
  parameter int NUM_REGS   = 32,
  parameter int UPPER_FROM = 16,
  localparam int IDX_W  = $clog2(NUM_REGS),
  localparam int WORD_W = 2 * DATA_W,
  localparam int PTR_BASE = NUM_REGS - 2 * gpr_pkg::PTR_PAIRS
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  rd_a_idx,
  output logic [DATA_W-1:0] rd_a_data,
  input  logic [IDX_W-1:0]  rd_b_idx,
  output logic [DATA_W-1:0] rd_b_data,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              pw_en,
  input  logic [1:0]        pw_sel,
  input  logic [WORD_W-1:0] pw_data,
  input  logic [1:0]        pr_sel,
  output logic [WORD_W-1:0] pr_data,
  output logic [WORD_W-1:0] zptr,
  input  logic [IDX_W-1:0]  chk_idx,
  input  logic              chk_upper_only,
  output logic              chk_ok
);
  logic [NUM_REGS-1:0][DATA_W-1:0] regs_q;

  gpr_storage #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_store (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pw_en(pw_en), .pw_sel(pw_sel), .pw_data(pw_data),
    .regs_q(regs_q)
  );

  gpr_rd_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rd_a (
    .clk(clk), .rst(rst), .idx(rd_a_idx), .regs(regs_q), .rd_q(rd_a_data)
  );

  gpr_rd_port #(.DATA_W(DATA_W), .NUM_REGS(NUM_REGS)) u_rd_b (
    .clk(clk), .rst(rst), .idx(rd_b_idx), .regs(regs_q), .rd_q(rd_b_data)
  );

  gpr_ptr_view #(.DATA_W(DATA_W)) u_ptr (
    .clk(clk), .rst(rst),
    .ptr_bytes(regs_q[NUM_REGS-1:PTR_BASE]),
    .pr_sel(pr_sel), .pr_q(pr_data), .zptr(zptr)
  );

  gpr_legal #(.NUM_REGS(NUM_REGS), .UPPER_FROM(UPPER_FROM)) u_legal (
    .clk(clk), .rst(rst),
    .chk_idx(chk_idx), .chk_upper_only(chk_upper_only), .chk_ok_q(chk_ok)
  );
endmodule

// File: rtl/gpr_bank_chk.sv
module gpr_bank_chk #(
  parameter int DATA_W     = 8,
  parameter int NUM_REGS   = 32,
  parameter int UPPER_FROM = 16,
  localparam int IDX_W    = $clog2(NUM_REGS),
  localparam int WORD_W   = 2 * DATA_W,
  localparam int PTR_BASE = NUM_REGS - 2 * gpr_pkg::PTR_PAIRS
) (
  input logic                            clk,
  input logic                            rst,
  input logic [IDX_W-1:0]                rd_a_idx,
  input logic [DATA_W-1:0]               rd_a_data,
  input logic                            wr_en,
  input logic [IDX_W-1:0]                wr_idx,
  input logic [DATA_W-1:0]               wr_data,
  input logic                            pw_en,
  input logic [1:0]                      pw_sel,
  input logic [WORD_W-1:0]               pw_data,
  input logic [IDX_W-1:0]                chk_idx,
  input logic                            chk_upper_only,
  input logic                            chk_ok,
  input logic [NUM_REGS-1:0][DATA_W-1:0] regs
);
  // armed: the previous edge already saw a completed reset
  logic seen = 1'b0;
  logic armed = 1'b0;
  always_ff @(posedge clk) begin
    seen  <= seen | rst;
    armed <= seen & !rst;
  end

  logic             ptr_live;
  logic [IDX_W-1:0] rel;
  logic             byte_shadowed;
  logic [IDX_W-1:0] pair_lo;
  assign ptr_live      = pw_en && (pw_sel != 2'd3);
  assign rel           = wr_idx - IDX_W'(PTR_BASE);
  assign byte_shadowed = ptr_live && (wr_idx >= IDX_W'(PTR_BASE)) &&
                         (rel[IDX_W-1:1] == (IDX_W-1)'(pw_sel));
  assign pair_lo       = IDX_W'(PTR_BASE) + IDX_W'({pw_sel, 1'b0});

  assert_read_old_R4: assert property (@(posedge clk) disable iff (rst)
    armed |-> rd_a_data == $past(regs[rd_a_idx]));

  assert_byte_write_R3: assert property (@(posedge clk) disable iff (rst)
    armed && $past(wr_en && !byte_shadowed) |-> regs[$past(wr_idx)] == $past(wr_data));

  assert_word_write_R6: assert property (@(posedge clk) disable iff (rst)
    armed && $past(ptr_live) |->
      {regs[$past(pair_lo) + IDX_W'(1)], regs[$past(pair_lo)]} == $past(pw_data));

  assert_no_sel3_write_R6: assert property (@(posedge clk) disable iff (rst)
    armed && $past(pw_en && pw_sel == 2'd3 && !wr_en) |-> $stable(regs));

  assert_low_illegal_R9: assert property (@(posedge clk) disable iff (rst)
    armed && $past(chk_upper_only && chk_idx < IDX_W'(UPPER_FROM)) |-> !chk_ok);

  assert_clear_legal_R9: assert property (@(posedge clk) disable iff (rst)
    armed && $past(!chk_upper_only) |-> chk_ok);
endmodule

bind gpr_bank gpr_bank_chk #(
  .DATA_W(DATA_W), .NUM_REGS(NUM_REGS), .UPPER_FROM(UPPER_FROM)
) u_chk (
  .clk(clk), .rst(rst), .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
  .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
  .pw_en(pw_en), .pw_sel(pw_sel), .pw_data(pw_data),
  .chk_idx(chk_idx), .chk_upper_only(chk_upper_only), .chk_ok(chk_ok),
  .regs(regs_q)
);

// File: tb/gpr_bank_bench.sv
`timescale 1ns/1ps
module gpr_bank_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [4:0]  rd_a_idx = '0, rd_b_idx = '0, wr_idx = '0, chk_idx = '0;
  logic [7:0]  rd_a_data, rd_b_data, wr_data = '0;
  logic        wr_en = 1'b0, pw_en = 1'b0, chk_upper_only = 1'b0;
  logic [1:0]  pw_sel = '0, pr_sel = '0;
  logic [15:0] pw_data = '0, pr_data, zptr;
  logic        chk_ok;

  always #2 clk = ~clk;  // 250 MHz

  gpr_bank u_gpr_bank (
    .clk(clk), .rst(rst),
    .rd_a_idx(rd_a_idx), .rd_a_data(rd_a_data),
    .rd_b_idx(rd_b_idx), .rd_b_data(rd_b_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pw_en(pw_en), .pw_sel(pw_sel), .pw_data(pw_data),
    .pr_sel(pr_sel), .pr_data(pr_data), .zptr(zptr),
    .chk_idx(chk_idx), .chk_upper_only(chk_upper_only), .chk_ok(chk_ok)
  );

  int n_chk = 0;
  int n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // behavioural reference, updated on every rising edge
  int  m [32];
  int  e_a = 0, e_b = 0, e_p = 0, e_z = 0, e_ok = 0;
  bit  live = 1'b0;
  always @(posedge clk) begin
    live = 1'b1;
    if (rst) begin
      foreach (m[k]) m[k] = 0;
      e_a = 0; e_b = 0; e_p = 0; e_ok = 0;
    end else begin
      e_a  = m[rd_a_idx];
      e_b  = m[rd_b_idx];
      e_p  = (pr_sel == 2'd3) ? 0 : (m[27 + 2*pr_sel] << 8) | m[26 + 2*pr_sel];
      e_ok = (chk_upper_only && chk_idx < 16) ? 0 : 1;
      if (wr_en) m[wr_idx] = wr_data;
      if (pw_en && pw_sel != 2'd3) begin
        m[26 + 2*pw_sel] = pw_data[7:0];
        m[27 + 2*pw_sel] = pw_data[15:8];
      end
    end
    e_z = (m[31] << 8) | m[30];
  end

  always @(negedge clk) begin
    if (live && !done) begin
      chk("R2 port A", rd_a_data, e_a);
      chk("R2 port B", rd_b_data, e_b);
      chk("R5 pointer read", pr_data, e_p);
      chk("R8 zptr", zptr, e_z);
      chk("R9 legality", chk_ok, e_ok);
    end
  end

  task automatic idle();
    wr_en = 1'b0; pw_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 read A in reset", rd_a_data, 0);
    chk("R1 chk_ok in reset", chk_ok, 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 zptr after reset", zptr, 0);
    chk("R1 pointer after reset", pr_data, 0);

    wr_en = 1'b1; wr_idx = 5'd5; wr_data = 8'hA5;
    @(negedge clk);
    idle(); rd_a_idx = 5'd5;
    @(negedge clk);
    chk("R3 byte write", rd_a_data, 'hA5);

    wr_en = 1'b1; wr_idx = 5'd5; wr_data = 8'h3C;
    @(negedge clk);
    chk("R4 old value on same-edge write", rd_a_data, 'hA5);
    idle();
    @(negedge clk);
    chk("R3 new value next cycle", rd_a_data, 'h3C);

    pw_en = 1'b1; pw_sel = 2'd2; pw_data = 16'h1234;
    wr_en = 1'b1; wr_idx = 5'd30; wr_data = 8'hFF;
    @(negedge clk);
    chk("R7 pointer write beats byte write", zptr, 'h1234);
    pw_sel = 2'd0; pw_data = 16'hABCD; wr_idx = 5'd4; wr_data = 8'h77;
    @(negedge clk);
    idle(); rd_a_idx = 5'd4; rd_b_idx = 5'd26; pr_sel = 2'd0;
    @(negedge clk);
    chk("R7 other byte write kept", rd_a_data, 'h77);
    chk("R5 X low byte in reg 26", rd_b_data, 'hCD);
    chk("R6 both bytes of X", pr_data, 'hABCD);

    pw_en = 1'b1; pw_sel = 2'd3; pw_data = 16'hBEEF;
    @(negedge clk);
    idle();
    @(negedge clk);
    chk("R6 select 3 leaves X", pr_data, 'hABCD);
    chk("R6 select 3 leaves Z", zptr, 'h1234);
    pr_sel = 2'd3;
    @(negedge clk);
    @(negedge clk);
    chk("R6 select 3 reads zero", pr_data, 0);

    chk_upper_only = 1'b1; chk_idx = 5'd15;
    @(negedge clk);
    chk("R9 index 15 upper-only", chk_ok, 0);
    chk_idx = 5'd16;
    @(negedge clk);
    chk("R9 index 16 upper-only", chk_ok, 1);
    chk_upper_only = 1'b0; chk_idx = 5'd0;
    @(negedge clk);
    chk("R9 clear on index 0", chk_ok, 1);

    for (int c = 0; c < 3000; c++) begin
      wr_en    = $urandom_range(0, 1);
      wr_idx   = ($urandom_range(0, 1) == 1) ? 5'($urandom_range(26, 31)) : 5'($urandom);
      wr_data  = 8'($urandom);
      pw_en    = $urandom_range(0, 1);
      pw_sel   = 2'($urandom);
      pw_data  = 16'($urandom);
      rd_a_idx = 5'($urandom);
      rd_b_idx = ($urandom_range(0, 1) == 1) ? 5'($urandom_range(26, 31)) : 5'($urandom);
      pr_sel   = 2'($urandom);
      chk_idx  = 5'($urandom);
      chk_upper_only = $urandom_range(0, 1);
      @(negedge clk);
    end
    idle();
    @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_chk++; n_fail++;
      $display("FAIL watchdog: got 0x0 expected 0x1 (run did not finish)");
      $display("  [TB] %0d tests run, %0d failed", n_chk, n_fail);
      $finish;
    end
  end
endmodule